// File: doc/BRIEF.md
# I2C Packet Command Master

This block is a single-master I2C engine that carries out one packet command per register write. A command word can hold any mix of a START with a 7-bit target address, one transmitted byte, one received byte (with an optional closing NAK) and a STOP. Software loads the byte to send into the data register, clears the status, writes the command, and polls the status register until the done flag comes up. The received byte and the bus-busy indication are read back from the data register.

Bus timing comes from a separate SCL timing block as a strobe, `tick`. Every bit cell, and each of the START and STOP sequences, takes four strobes. The pins are open drain: an `_oe` output of 1 pulls the line low, and the real line level comes back on `scl_in` and `sda_in`. When a command leaves out STOP, SCL stays held low after it, so the next command can carry on the same transfer without addressing the target again.

Top module: `i2c_pkt_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, the status register (index 2) reads 0 and the busy bit (data register bit 16) reads 0.
- R2: A write to the command register (index 0) starts a command only when bit 16 of the word is 1 and no command is running. Any other command write changes nothing.
- R3: With command bit 0 (START) set, the engine sends a START and then the address byte, MSB first. The address byte is bits [30:24] of the command followed by an R/W bit, which is 1 when bit 3 is set and 0 otherwise. An SDA level of low in the ninth bit counts as the target's ACK.
- R4: With command bit 1 set (and bit 3 clear), the engine sends the byte held in data register bits [7:0], MSB first, and samples the target's acknowledge.
- R5: With command bit 3 set, the engine receives one byte, which is then read from data register bits [15:8]. The engine answers ACK, or NAK when command bit 4 is set.
- R6: Command bit 5 ends the command with a STOP, after which both lines are released. Without it, SCL is held low (`scl_oe`=1) once the command completes. A following command without START then continues the same transfer.
- R7: Status bit 16 (done) is set when a command completes. Bit 0 is set by each target ACK and bit 1 by each target NAK within the command. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: A NAK on the address skips the data phase. The STOP is still sent if it was requested, and then done is set.
- R9: A command with START and STOP but no data bit performs an address probe, and its ACK or NAK is reported.
- R10: The busy bit is 1 from the start of a command until a STOP completes, including while SCL is held between commands.
- R11: The outputs `scl_oe` and `sda_oe` change only in the cycle after a `tick` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Quarter-bit strobe from the SCL timing block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 command, 1 data, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register selected by `reg_addr` |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A wrong phase counter or bit counter moves an SDA edge into a window where SCL is high. The attached target model then sees a false START or STOP, and the damage shows up at the completion of that same command: the acknowledge flags come back wrong, the target never captures the byte, or the received byte is shifted. A wrong next-state choice after the acknowledge bit shows in the busy bit and in `scl_oe` as soon as done rises, because a transfer that was skipped or wrongly continued leaves the bus held or released when it should not be. Flag errors are visible on the first status read after completion.

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_TX, S_RX, S_STOP} st_t;

  st_t        state, nx_first, nx_data, nx_end;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh, tx_buf, rx_buf;
  logic [6:0] c_addr;
  logic       c_tx, c_rx, c_last, c_stop;
  logic       own, got_ack, st_ack, st_nak, st_done;
  logic       engine_on, busy, launch, clr;

  function automatic st_t pick(input logic rx, input logic tx, input logic sp);
    if (rx)      return S_RX;
    else if (tx) return S_TX;
    else if (sp) return S_STOP;
    else         return S_IDLE;
  endfunction

  assign engine_on = (state != S_IDLE);
  assign busy      = own | engine_on;
  assign launch    = reg_wr && reg_addr == 2'd0 && reg_wdata[16] && !engine_on;
  assign clr       = reg_wr && reg_addr == 2'd2;

  always_comb begin
    nx_first = pick(reg_wdata[3], reg_wdata[1], reg_wdata[5]);
    nx_data  = pick(c_rx, c_tx, c_stop);
    nx_end   = c_stop ? S_STOP : S_IDLE;
  end

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = {15'b0, busy, rx_buf, tx_buf};
      2'd2:    reg_rdata = {15'b0, st_done, 14'b0, st_nak, st_ack};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      q       <= 2'd0;
      bitn    <= 4'd0;
      sh      <= 8'd0;
      tx_buf  <= 8'd0;
      rx_buf  <= 8'd0;
      c_addr  <= 7'd0;
      c_tx    <= 1'b0;
      c_rx    <= 1'b0;
      c_last  <= 1'b0;
      c_stop  <= 1'b0;
      own     <= 1'b0;
      got_ack <= 1'b0;
      st_ack  <= 1'b0;
      st_nak  <= 1'b0;
      st_done <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      if (clr) begin
        if (reg_wdata[0])  st_ack  <= 1'b0;
        if (reg_wdata[1])  st_nak  <= 1'b0;
        if (reg_wdata[16]) st_done <= 1'b0;
      end
      if (reg_wr && reg_addr == 2'd1) tx_buf <= reg_wdata[7:0];

      if (state == S_IDLE) begin
        if (launch) begin
          c_addr <= reg_wdata[30:24];
          c_tx   <= reg_wdata[1];
          c_rx   <= reg_wdata[3];
          c_last <= reg_wdata[4];
          c_stop <= reg_wdata[5];
          q      <= 2'd0;
          bitn   <= 4'd0;
          if (reg_wdata[0]) state <= S_START;
          else begin
            state <= nx_first;
            if (nx_first == S_TX)   sh      <= tx_buf;
            if (nx_first == S_IDLE) st_done <= 1'b1;
          end
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (state)
          S_START: begin
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1;
                own    <= 1'b1;
                sh     <= {c_addr, c_rx};
                bitn   <= 4'd0;
                state  <= S_ADDR;
              end
            endcase
          end
          S_ADDR, S_TX, S_RX: begin
            case (q)
              2'd0: begin
                if (bitn == 4'd8) sda_oe <= (state == S_RX) && !c_last;
                else              sda_oe <= (state != S_RX) && !sh[7];
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn != 4'd8) sh <= {sh[6:0], sda_in};
                else if (state != S_RX) begin
                  got_ack <= !sda_in;
                  if (!sda_in) st_ack <= 1'b1;
                  else         st_nak <= 1'b1;
                end
              end
              default: begin
                scl_oe <= 1'b1;
                if (bitn != 4'd8) bitn <= bitn + 4'd1;
                else begin
                  bitn <= 4'd0;
                  if (state == S_RX) rx_buf <= sh;
                  if (state == S_ADDR && got_ack) begin
                    state <= nx_data;
                    if (nx_data == S_TX)   sh      <= tx_buf;
                    if (nx_data == S_IDLE) st_done <= 1'b1;
                  end else begin
                    state <= nx_end;
                    if (nx_end == S_IDLE) st_done <= 1'b1;
                  end
                end
              end
            endcase
          end
          S_STOP: begin
            case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                own     <= 1'b0;
                state   <= S_IDLE;
                st_done <= 1'b1;
              end
            endcase
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_pkt_master_chk.sv
module i2c_pkt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        busy,
  input logic        own,
  input logic        engine_on,
  input logic        st_done
);

  p_oe_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe != $past(scl_oe) || sda_oe != $past(sda_oe)) |-> $past(tick));

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(engine_on));

  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[16] && !engine_on) |=> !st_done);

  p_no_pkt_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!engine_on && reg_wr && reg_addr == 2'd0 && !reg_wdata[16]) |=> !engine_on);

  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own && !engine_on) |-> scl_oe);

endmodule

bind i2c_pkt_master i2c_pkt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
  .own(own), .engine_on(engine_on), .st_done(st_done)
);

// File: tb/i2c_pkt_master_tb.sv
module i2c_pkt_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe;
  logic        s_sda_low = 1'b0;
  wire         scl = !scl_oe;
  wire         sda = !sda_oe && !s_sda_low;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  i2c_pkt_master u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl), .sda_in(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // target model at address 0x50
  localparam logic [6:0] SADDR = 7'h50;
  logic [7:0] s_sh = 8'h00;
  logic [7:0] s_rd = 8'hA5;
  logic [7:0] s_wr = 8'h00;
  logic       s_mack = 1'b0;
  logic       s_nak_data = 1'b0;
  int         s_cnt = 0;
  int         s_ph = 0;

  always @(negedge sda) if (scl) begin s_ph = 1; s_cnt = -1; s_sda_low = 1'b0; end
  always @(posedge sda) if (scl) begin s_ph = 0; s_sda_low = 1'b0; end

  always @(posedge scl) begin
    if ((s_ph == 1 || s_ph == 2) && s_cnt >= 0 && s_cnt < 8) s_sh = {s_sh[6:0], sda};
    if (s_ph == 3 && s_cnt == 8) s_mack = !sda;
  end

  always @(negedge scl) if (s_ph != 0) begin
    s_cnt++;
    if (s_cnt == 9) begin
      s_cnt = 0;
      if (s_ph == 1) s_ph = (s_sh[7:1] == SADDR) ? (s_sh[0] ? 3 : 2) : 0;
      else if (s_ph == 2) s_wr = s_sh;
      else if (s_ph == 3) begin s_rd = s_rd + 8'd1; if (!s_mack) s_ph = 0; end
    end
    s_sda_low = 1'b0;
    if (s_cnt == 8 && s_ph == 1 && s_sh[7:1] == SADDR) s_sda_low = 1'b1;
    if (s_cnt == 8 && s_ph == 2 && !s_nak_data) s_sda_low = 1'b1;
    if (s_ph == 3 && s_cnt < 8) s_sda_low = !s_rd[7 - s_cnt];
  end

  // cmd, tx, status, rx, check rx, busy after, check written byte, written byte
  localparam int VN = 9;
  localparam logic [90:0] VEC [0:VN-1] = '{
    {32'h5001_0021, 8'h00, 32'h0001_0001, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {32'h5101_0021, 8'h00, 32'h0001_0002, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {32'h5001_0023, 8'h5A, 32'h0001_0001, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5A},
    {32'h5001_0039, 8'h00, 32'h0001_0001, 8'hA5, 1'b1, 1'b0, 1'b0, 8'h00},
    {32'h5001_0003, 8'h11, 32'h0001_0001, 8'h00, 1'b0, 1'b1, 1'b1, 8'h11},
    {32'h5001_0022, 8'h22, 32'h0001_0001, 8'h00, 1'b0, 1'b0, 1'b1, 8'h22},
    {32'h5001_0009, 8'h00, 32'h0001_0001, 8'hA6, 1'b1, 1'b1, 1'b0, 8'h00},
    {32'h5001_0038, 8'h00, 32'h0001_0000, 8'hA7, 1'b1, 1'b0, 1'b0, 8'h00},
    {32'h5101_0023, 8'h77, 32'h0001_0002, 8'h00, 1'b0, 1'b0, 1'b1, 8'h22}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd_reg(2'd2, s);
      if (s[16]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [90:0] v;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 scl_oe reset", {31'b0, scl_oe}, 32'd0);
    chk("R1 sda_oe reset", {31'b0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    rd_reg(2'd2, d); chk("R1 status reset", d, 32'd0);
    rd_reg(2'd1, d); chk("R1 busy reset", {31'b0, d[16]}, 32'd0);

    // R2: command word without packet enable is ignored
    wr_reg(2'd0, 32'h5000_0021);
    repeat (80) @(negedge clk);
    rd_reg(2'd2, d); chk("R2 no-enable status", d, 32'd0);
    chk("R2 no-enable scl_oe", {31'b0, scl_oe}, 32'd0);

    for (int i = 0; i < VN; i++) begin
      v = VEC[i];
      wr_reg(2'd1, {24'b0, v[58:51]});
      wr_reg(2'd2, 32'h0001_0003);
      wr_reg(2'd0, v[90:59]);
      wait_done();
      rd_reg(2'd2, d);
      chk($sformatf("R7 R3 R8 R9 status vec%0d", i), d, v[50:19]);
      rd_reg(2'd1, d);
      chk($sformatf("R10 busy vec%0d", i), {31'b0, d[16]}, {31'b0, v[9]});
      chk($sformatf("R6 scl hold vec%0d", i), {31'b0, scl_oe}, {31'b0, v[9]});
      if (v[10]) chk($sformatf("R5 rx byte vec%0d", i), {24'b0, d[15:8]}, {24'b0, v[18:11]});
      if (v[8])  chk($sformatf("R4 target byte vec%0d", i), {24'b0, s_wr}, {24'b0, v[7:0]});
    end

    // R2: command written while one runs is ignored
    wr_reg(2'd2, 32'h0001_0003);
    wr_reg(2'd0, 32'h5001_0021);
    repeat (4) @(negedge clk);
    wr_reg(2'd0, 32'h5101_0021);
    wait_done();
    rd_reg(2'd2, d); chk("R2 busy write ignored", d, 32'h0001_0001);

    // R7: write-one-to-clear per bit
    wr_reg(2'd2, 32'h0000_0001);
    rd_reg(2'd2, d); chk("R7 clear ack only", d, 32'h0001_0000);
    wr_reg(2'd2, 32'h0001_0000);
    rd_reg(2'd2, d); chk("R7 clear done", d, 32'd0);

    // R4 R8: data byte refused by target
    s_nak_data = 1'b1;
    wr_reg(2'd1, 32'h0000_0033);
    wr_reg(2'd0, 32'h5001_0023);
    wait_done();
    rd_reg(2'd2, d); chk("R4 data nak status", d, 32'h0001_0003);
    rd_reg(2'd1, d); chk("R8 released after nak", {31'b0, d[16]}, 32'd0);
    s_nak_data = 1'b0;

    summary();
  end

endmodule